// File: doc/BRIEF.md
# Chained BCD Seven-Segment Display Decoder

This block turns a row of binary-coded decimal digits (weights 8, 4, 2, 1) into active-low drives for seven-segment displays. Each digit has its own segment field with bits a through g. Three controls are shared by the whole row. Lamp test lights every segment. Blank turns every segment off. A head ripple input starts zero suppression.

Each digit cell has a ripple-blanking input and a combined blank/ripple node. The node is a blank-in and a ripple-out joined by a wired AND. A cell blanks a zero digit only when its ripple input is asserted, and it then passes blanking on to the next cell. A mode input sets the direction of the chain. In leading-zero mode the chain runs from the most significant digit down to the least significant digit. In trailing-zero mode it runs from the least significant digit up to the most significant digit.

The segment outputs and the ripple output from the end of the chain are registered. Both appear on the clock edge that samples the inputs.

Top module: `segrow_decoder`

## Requirements
- R1: While `rst` is high and after the edge that samples it, every bit of `seg_n_o` is 1 (all segments dark) and `ripple_out_n` is 1.
- R2: With `blank_n`=1, `lamp_test_n`=1 and no ripple blanking reaching a digit, the digit's 7-bit field (bit0=a … bit6=g, 0 = lit) shows the glyph for that code. The active-high glyphs are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F. A zero whose ripple input is not asserted shows the glyph for 0.
- R3: Codes 10 to 15 show a dash, which is segment g only (field value 7'b0111111).
- R4: With `blank_n`=1 and `lamp_test_n`=0, every field is 7'b0000000 whatever the digits are. Zero suppression does not act and does not propagate, so `ripple_out_n` stays 1.
- R5: With `blank_n`=0, every field is 7'b1111111 and `ripple_out_n` is 0. This overrides lamp test and the digit values.
- R6: When `trail_mode`=0 and `head_rbi_n`=0, the chain runs from digit NUM_DIGITS-1 down to digit 0. Zeros above the highest nonzero digit are dark, and every later digit shows its glyph.
- R7: When `trail_mode`=1 and `head_rbi_n`=0, the chain runs from digit 0 up to digit NUM_DIGITS-1. Zeros below the lowest nonzero digit are dark, and every later digit shows its glyph.
- R8: When `head_rbi_n`=1, no digit is blanked by zero suppression, and `ripple_out_n` is 1 while `blank_n` is 1.
- R9: With `blank_n`=1, `lamp_test_n`=1 and `head_rbi_n`=0, `ripple_out_n` is 0 exactly when every digit is zero.
- R10: Each output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digit_i | input | 4*NUM_DIGITS | BCD digits, digit 0 (least significant) in bits 3:0 |
| lamp_test_n | input | 1 | Active-low lamp test |
| blank_n | input | 1 | Active-low blank for the whole row |
| head_rbi_n | input | 1 | Active-low ripple-blanking input at the head of the chain |
| trail_mode | input | 1 | 0: suppress leading zeros, 1: suppress trailing zeros |
| seg_n_o | output | 7*NUM_DIGITS | Active-low segments, digit i in bits 7i+6:7i (a in the low bit) |
| ripple_out_n | output | 1 | Active-low ripple output from the last digit of the chain |

## Verification
Every result, the segment fields and the ripple output alike, is due on the first rising edge after the inputs are driven. The bench drives each stimulus on a falling edge, waits for the next rising edge, and samples one time unit later, so each check looks at the register loaded from that stimulus. The R10 scenario changes the inputs and samples before the edge to confirm that the old value still holds. It then samples after the edge to see the new value. The bound checker states its rules with one-cycle implications that match this latency.

// File: rtl/segrow_pkg.sv
package segrow_pkg;

  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  typedef enum logic {
    CHAIN_FROM_MSD = 1'b0,
    CHAIN_FROM_LSD = 1'b1
  } chain_dir_e;

  // Active-high glyph, bit0 = a ... bit6 = g
  function automatic logic [SEG_W-1:0] glyph_on(input logic [BCD_W-1:0] code);
    logic [SEG_W-1:0] g;
    case (code)
      4'd0:    g = 7'h3F;
      4'd1:    g = 7'h06;
      4'd2:    g = 7'h5B;
      4'd3:    g = 7'h4F;
      4'd4:    g = 7'h66;
      4'd5:    g = 7'h6D;
      4'd6:    g = 7'h7D;
      4'd7:    g = 7'h07;
      4'd8:    g = 7'h7F;
      4'd9:    g = 7'h6F;
      default: g = 7'h40;  // dash for non-decimal codes
    endcase
    return g;
  endfunction

endpackage

// File: rtl/segdigit_cell.sv
module segdigit_cell
  import segrow_pkg::*;
(
  input  logic [BCD_W-1:0] bcd,
  input  logic             lamp_test_n,
  input  logic             rbi_n,
  input  logic             bi_n,
  output logic [SEG_W-1:0] seg_n,
  output logic             node_n
);

  logic is_zero;
  logic rbo_n;

  assign is_zero = (bcd == '0);
  // Ripple output pulls low only for a suppressed zero outside lamp test
  assign rbo_n   = ~(is_zero & ~rbi_n & lamp_test_n);
  // Wired-AND of the external blank and the ripple output
  assign node_n  = bi_n & rbo_n;

  always_comb begin
    if (!node_n)           seg_n = '1;
    else if (!lamp_test_n) seg_n = '0;
    else                   seg_n = ~glyph_on(bcd);
  end

endmodule

// File: rtl/segrow_chain.sv
module segrow_chain
  import segrow_pkg::*;
#(
  parameter int         NUM_DIGITS = 4,
  parameter chain_dir_e DIR        = CHAIN_FROM_MSD,
  localparam int        DW         = NUM_DIGITS * BCD_W,
  localparam int        SW         = NUM_DIGITS * SEG_W
) (
  input  logic [DW-1:0] digits,
  input  logic          lamp_test_n,
  input  logic          blank_n,
  input  logic          head_rbi_n,
  output logic [SW-1:0] seg_n,
  output logic          tail_n
);

  logic [NUM_DIGITS-1:0] node_n;
  logic [NUM_DIGITS-1:0] rbi_n;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_cell
    if (DIR == CHAIN_FROM_MSD) begin : g_down
      if (i == NUM_DIGITS - 1) begin : g_head
        assign rbi_n[i] = head_rbi_n;
      end else begin : g_link
        assign rbi_n[i] = node_n[i+1];
      end
    end else begin : g_up
      if (i == 0) begin : g_head
        assign rbi_n[i] = head_rbi_n;
      end else begin : g_link
        assign rbi_n[i] = node_n[i-1];
      end
    end

    segdigit_cell u_cell (
      .bcd         (digits[i*BCD_W +: BCD_W]),
      .lamp_test_n (lamp_test_n),
      .rbi_n       (rbi_n[i]),
      .bi_n        (blank_n),
      .seg_n       (seg_n[i*SEG_W +: SEG_W]),
      .node_n      (node_n[i])
    );
  end

  if (DIR == CHAIN_FROM_MSD) begin : g_tail_lsd
    assign tail_n = node_n[0];
  end else begin : g_tail_msd
    assign tail_n = node_n[NUM_DIGITS-1];
  end

endmodule

// File: rtl/segrow_decoder.sv
module segrow_decoder
  import segrow_pkg::*;
#(
  parameter int  NUM_DIGITS = 4,
  localparam int DW         = NUM_DIGITS * BCD_W,
  localparam int SW         = NUM_DIGITS * SEG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] digit_i,
  input  logic          lamp_test_n,
  input  logic          blank_n,
  input  logic          head_rbi_n,
  input  logic          trail_mode,
  output logic [SW-1:0] seg_n_o,
  output logic          ripple_out_n
);

  logic [SW-1:0] seg_lead, seg_trail, seg_sel;
  logic          tail_lead, tail_trail, tail_sel;

  segrow_chain #(.NUM_DIGITS(NUM_DIGITS), .DIR(CHAIN_FROM_MSD)) u_lead (
    .digits      (digit_i),
    .lamp_test_n (lamp_test_n),
    .blank_n     (blank_n),
    .head_rbi_n  (head_rbi_n),
    .seg_n       (seg_lead),
    .tail_n      (tail_lead)
  );

  segrow_chain #(.NUM_DIGITS(NUM_DIGITS), .DIR(CHAIN_FROM_LSD)) u_trail (
    .digits      (digit_i),
    .lamp_test_n (lamp_test_n),
    .blank_n     (blank_n),
    .head_rbi_n  (head_rbi_n),
    .seg_n       (seg_trail),
    .tail_n      (tail_trail)
  );

  assign seg_sel  = trail_mode ? seg_trail  : seg_lead;
  assign tail_sel = trail_mode ? tail_trail : tail_lead;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n_o      <= '1;
      ripple_out_n <= 1'b1;
    end else begin
      seg_n_o      <= seg_sel;
      ripple_out_n <= tail_sel;
    end
  end

endmodule

// File: rtl/segrow_decoder_chk.sv
module segrow_decoder_chk
  import segrow_pkg::*;
#(
  parameter int  NUM_DIGITS = 4,
  localparam int DW         = NUM_DIGITS * BCD_W,
  localparam int SW         = NUM_DIGITS * SEG_W
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] digit_i,
  input logic          lamp_test_n,
  input logic          blank_n,
  input logic          head_rbi_n,
  input logic          trail_mode,
  input logic [SW-1:0] seg_n_o,
  input logic          ripple_out_n
);

  // R1
  a_r1_reset_dark: assert property (@(posedge clk)
    rst |=> (seg_n_o == '1) && ripple_out_n);

  // R5
  a_r5_blank_dark: assert property (@(posedge clk) disable iff (rst)
    !blank_n |=> (seg_n_o == '1) && !ripple_out_n);

  // R4
  a_r4_lamp_all_on: assert property (@(posedge clk) disable iff (rst)
    (blank_n && !lamp_test_n) |=> (seg_n_o == '0) && ripple_out_n);

  // R8
  a_r8_no_head_no_ripple: assert property (@(posedge clk) disable iff (rst)
    (blank_n && head_rbi_n) |=> ripple_out_n);

  // R3
  a_r3_dash_low_digit: assert property (@(posedge clk) disable iff (rst)
    (blank_n && lamp_test_n && digit_i[BCD_W-1:0] >= 4'd10)
      |=> seg_n_o[SEG_W-1:0] == 7'b0111111);

  // R9
  a_r9_ripple_all_zero: assert property (@(posedge clk) disable iff (rst)
    (blank_n && lamp_test_n && !head_rbi_n)
      |=> (ripple_out_n == ($past(digit_i) != '0)));

  // R10
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    ($stable(digit_i) && $stable(lamp_test_n) && $stable(blank_n) &&
     $stable(head_rbi_n) && $stable(trail_mode) && !$past(rst))
      |=> $stable(seg_n_o));

endmodule

bind segrow_decoder segrow_decoder_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .digit_i      (digit_i),
  .lamp_test_n  (lamp_test_n),
  .blank_n      (blank_n),
  .head_rbi_n   (head_rbi_n),
  .trail_mode   (trail_mode),
  .seg_n_o      (seg_n_o),
  .ripple_out_n (ripple_out_n)
);

// File: tb/segrow_decoder_test.sv
module segrow_decoder_test;

  localparam int PERIOD = 10;
  localparam int ND     = 4;

  localparam logic [6:0] DARK = 7'b1111111;
  localparam logic [6:0] ALL  = 7'b0000000;
  localparam logic [6:0] DASH = 7'b0111111;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   digit_i = '0;
  logic          lamp_test_n = 1'b1;
  logic          blank_n = 1'b1;
  logic          head_rbi_n = 1'b1;
  logic          trail_mode = 1'b0;
  logic [27:0]   seg_n_o;
  logic          ripple_out_n;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  segrow_decoder #(.NUM_DIGITS(ND)) uut (
    .clk(clk), .rst(rst), .digit_i(digit_i), .lamp_test_n(lamp_test_n),
    .blank_n(blank_n), .head_rbi_n(head_rbi_n), .trail_mode(trail_mode),
    .seg_n_o(seg_n_o), .ripple_out_n(ripple_out_n)
  );

  // Expected active-low glyph, taken from the requirement table
  function automatic logic [6:0] lit(input int code);
    case (code)
      0: return ~7'h3F;  1: return ~7'h06;  2: return ~7'h5B;
      3: return ~7'h4F;  4: return ~7'h66;  5: return ~7'h6D;
      6: return ~7'h7D;  7: return ~7'h07;  8: return ~7'h7F;
      9: return ~7'h6F;  default: return DASH;
    endcase
  endfunction

  task automatic check_seg(input int idx, input logic [6:0] exp, input string req);
    compared++;
    if (seg_n_o[idx*7 +: 7] !== exp) begin
      mismatched++;
      $display("FAIL %s digit %0d: actual %b expected %b", req, idx, seg_n_o[idx*7 +: 7], exp);
    end
  endtask

  task automatic check_rip(input logic exp, input string req);
    compared++;
    if (ripple_out_n !== exp) begin
      mismatched++;
      $display("FAIL %s ripple: actual %b expected %b", req, ripple_out_n, exp);
    end
  endtask

  task automatic apply(input logic [15:0] d, input logic lt, input logic bl,
                       input logic rbi, input logic md);
    @(negedge clk);
    digit_i = d; lamp_test_n = lt; blank_n = bl; head_rbi_n = rbi; trail_mode = md;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    for (int i = 0; i < ND; i++) check_seg(i, DARK, "R1");
    check_rip(1'b1, "R1");
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_glyphs;
    for (int c = 0; c < 16; c += 4) begin
      apply({4'(c+3), 4'(c+2), 4'(c+1), 4'(c)}, 1'b1, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < ND; i++)
        check_seg(i, lit(c+i), (c+i) >= 10 ? "R3" : "R2");
    end
    // zero with ripple input deasserted still shows 0 (R2, R8)
    apply(16'h0000, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < ND; i++) check_seg(i, lit(0), "R8");
    check_rip(1'b1, "R8");
  endtask

  task automatic t_lamp;
    apply(16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < ND; i++) check_seg(i, ALL, "R4");
    check_rip(1'b1, "R4");
  endtask

  task automatic t_blank;
    apply(16'h1234, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < ND; i++) check_seg(i, DARK, "R5");
    check_rip(1'b0, "R5");
  endtask

  task automatic t_leading;
    apply(16'h0050, 1'b1, 1'b1, 1'b0, 1'b0);
    check_seg(3, DARK, "R6"); check_seg(2, DARK, "R6");
    check_seg(1, lit(5), "R6"); check_seg(0, lit(0), "R6");
    check_rip(1'b1, "R9");
    apply(16'h0000, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < ND; i++) check_seg(i, DARK, "R6");
    check_rip(1'b0, "R9");
  endtask

  task automatic t_trailing;
    apply(16'h0500, 1'b1, 1'b1, 1'b0, 1'b1);
    check_seg(0, DARK, "R7"); check_seg(1, DARK, "R7");
    check_seg(2, lit(5), "R7"); check_seg(3, lit(0), "R7");
    check_rip(1'b1, "R9");
    apply(16'h0000, 1'b1, 1'b1, 1'b0, 1'b1);
    check_rip(1'b0, "R9");
  endtask

  task automatic t_latency;
    apply(16'h0001, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    digit_i = 16'h0007;
    #1;
    check_seg(0, lit(1), "R10");
    @(posedge clk); #1;
    check_seg(0, lit(7), "R10");
  endtask

  initial begin
    t_reset();
    t_glyphs();
    t_lamp();
    t_blank();
    t_leading();
    t_trailing();
    t_latency();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule